// File: doc/BRIEF.md
# Triggered frame-start gate

This block decides when each frame of a row-scanned image readout begins. In free-running mode a frame starts by itself: the programmed frame length runs out, a programmable padding delay follows, and the next frame begins. In triggered mode an outside controller sets the frame rate instead. Near the end of each frame the block arms itself. After the frame it holds the row-reset and row-read pointers paused until a rising edge arrives on the asynchronous trigger input, and it starts the next frame on that edge.

After a frame starts in triggered mode, the block stays disarmed for the frame length minus a fixed lead of 16 clocks. Any trigger edge in that window is dropped. An edge that arrives in the armed tail of a running frame is held, and the next frame follows the current one with no pause. Triggered mode needs both enable inputs high. It is chosen at each frame boundary, so clearing an enable never shortens a frame already running. A counter reports how many clocks the last wait lasted, so that trigger jitter can be measured.

The block carries no data stream. Every pin is a plain control or status level or pulse, so no valid/ready handshake or back-pressure applies.

Top module: `vd_frame_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `frame_start` is 0, `armed` is 0, `rows_run` is 1 and `wait_clks` is 0.
- R2: Triggered mode is in force only when `gpi_en` and `trig_sel` are both 1. With either one at 0, frames free-run and the trigger input has no effect.
- R3: In free-running mode, successive `frame_start` pulses are exactly L + D + 1 clocks apart. L is the effective frame length (R12) and D is `pad_clks`.
- R4: In triggered mode, the cycle after a frame's last clock shows `armed`=1 and `rows_run`=0. The pause lasts until a trigger rising edge. `frame_start` then goes high 3 clocks after the first clock edge that samples the trigger high (2 synchronizer stages plus 1 decision register), and `rows_run` returns to 1 in that same cycle.
- R5: A trigger input held high starts at most one frame. Only a low-to-high transition is accepted.
- R6: After a triggered-mode `frame_start`, `armed` stays 0 for L-16 cycles, counting the pulse cycle. It goes to 1 in cycle L-16 of the frame, where the pulse cycle is cycle 0.
- R7: A rising edge that arrives while disarmed is discarded. The block re-arms and waits for a later edge.
- R8: A rising edge accepted in the armed tail of a running frame makes the next `frame_start` follow immediately after that frame's last clock. `rows_run` stays 1 throughout, and `armed` drops once the edge has been taken.
- R9: Clearing an enable in the middle of a triggered frame lets that frame run to its full length. The block then pads for D+1 clocks and starts the next frame without arming.
- R10: `wait_clks` is cleared on entry to the paused wait. It adds one for each paused cycle, saturates at its maximum and holds its value after the wait ends.
- R11: A trigger input that is high while reset is released does not start a frame.
- R12: A `frame_len` below 17 is treated as 17, so every frame has at least one disarmed cycle.
- R13: `frame_start` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpi_en | input | 1 | Trigger-input enable; both enables must be 1 for triggered mode |
| trig_sel | input | 1 | Triggered-mode select |
| vd_in | input | 1 | Asynchronous trigger input; its rising edge starts a frame |
| frame_len | input | LEN_W | Frame length in clocks (values below 17 are raised to 17) |
| pad_clks | input | DLY_W | Free-running padding delay after each frame |
| frame_start | output | 1 | One-clock pulse in the first cycle of each frame |
| armed | output | 1 | High while a trigger edge would be accepted |
| rows_run | output | 1 | Low while the row pointers are held paused |
| wait_clks | output | WAIT_W | Length of the current or last paused wait, in clocks |

## Verification
A corrupted phase register shows within one frame. The block pauses without arming or arms without pausing, a `frame_start` comes early or late against L + D + 1, or a trigger edge is dropped. A miscounted frame counter moves both the re-arm point (cycle L-16) and the next pulse, so checking at the exact cycle catches it within the same frame. A pending-edge flag stuck set or clear shows at the next frame boundary, as an unwanted pause or as a back-to-back start. A trigger edge detector that fires on a level or at reset release shows as an extra `frame_start` a few clocks later.

// File: rtl/vfg_pkg.sv
package vfg_pkg;
  // Phase of the frame-start gate
  typedef enum logic [1:0] {
    PH_PAD = 2'd0,  // free-running padding after a frame
    PH_RUN = 2'd1,  // frame in progress
    PH_ARM = 2'd2   // paused, waiting for a trigger edge
  } phase_t;

  localparam int unsigned REARM_LEAD_DEF = 16;
endpackage

// File: rtl/vfg_sync_edge.sv
module vfg_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned NS = (STAGES < 2) ? 2 : STAGES;

  // Stages and previous value reset high: a level that is already high never looks like an edge
  logic [NS-1:0] sh;
  logic          prev;

  generate
    for (genvar g = 0; g < NS; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[0] <= 1'b1;
          else        sh[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[g] <= 1'b1;
          else        sh[g] <= sh[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= sh[NS-1];

  assign rise = sh[NS-1] & ~prev;

  // R5: an edge is seen for one cycle only, so a held level cannot retrigger
  a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/vfg_upcnt.sv
module vfg_upcnt #(
  parameter int unsigned W   = 16,
  parameter bit          SAT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] QMAX = '1;

  logic hold;

  generate
    if (SAT) begin : g_sat
      assign hold = (q == QMAX);
    end else begin : g_wrap
      assign hold = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          q <= '0;
    else if (clr)        q <= '0;
    else if (inc && !hold) q <= q + 1'b1;

  generate
    if (SAT) begin : g_sat_chk
      // R10: a saturating count never wraps to zero without a clear
      a_r10_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q) == QMAX && !$past(clr)) |-> q == QMAX);
    end
  endgenerate
endmodule

// File: rtl/vd_frame_gate.sv
module vd_frame_gate #(
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned DLY_W       = 16,
  parameter int unsigned WAIT_W      = 16,
  parameter int unsigned REARM_LEAD  = vfg_pkg::REARM_LEAD_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gpi_en,
  input  logic              trig_sel,
  input  logic              vd_in,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [DLY_W-1:0]  pad_clks,
  output logic              frame_start,
  output logic              armed,
  output logic              rows_run,
  output logic [WAIT_W-1:0] wait_clks
);
  import vfg_pkg::*;

  localparam logic [LEN_W-1:0] LEAD    = LEN_W'(REARM_LEAD);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(REARM_LEAD + 1);

  phase_t            ph, ph_nx;
  logic              pend, pend_nx;
  logic              start;
  logic              rise;
  logic              en;
  logic [LEN_W-1:0]  len_eff;
  logic [LEN_W-1:0]  fcnt;
  logic [DLY_W-1:0]  dcnt;
  logic              last, tail, tail_arm;

  vfg_sync_edge #(.STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst_n(rst_n), .async_in(vd_in), .rise(rise)
  );

  assign en       = gpi_en & trig_sel;
  assign len_eff  = (frame_len < MIN_LEN) ? MIN_LEN : frame_len;
  assign last     = (fcnt == len_eff - 1'b1);
  assign tail     = (fcnt >= len_eff - LEAD);
  assign tail_arm = (ph == PH_RUN) & en & tail & ~pend;

  // Frame position: cleared on a start, advanced while a frame runs
  vfg_upcnt #(.W(LEN_W), .SAT(1'b0)) i_fcnt (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(ph == PH_RUN), .q(fcnt)
  );

  // Padding position: held at zero outside the padding phase
  vfg_upcnt #(.W(DLY_W), .SAT(1'b0)) i_dcnt (
    .clk(clk), .rst_n(rst_n), .clr(ph != PH_PAD), .inc(ph == PH_PAD), .q(dcnt)
  );

  // Wait meter: cleared on entry to the pause, counts each paused cycle
  vfg_upcnt #(.W(WAIT_W), .SAT(1'b1)) i_wait (
    .clk(clk), .rst_n(rst_n),
    .clr((ph != PH_ARM) && (ph_nx == PH_ARM)),
    .inc(ph == PH_ARM), .q(wait_clks)
  );

  always_comb begin
    ph_nx   = ph;
    pend_nx = pend;
    start   = 1'b0;
    unique case (ph)
      PH_PAD: begin
        if (en) begin
          ph_nx = PH_ARM;
        end else if (dcnt == pad_clks) begin
          ph_nx = PH_RUN;
          start = 1'b1;
        end
      end
      PH_RUN: begin
        if (last) begin
          pend_nx = 1'b0;
          if (en && (pend || (tail_arm && rise))) begin
            start = 1'b1;
          end else if (en) begin
            ph_nx = PH_ARM;
          end else begin
            ph_nx = PH_PAD;
          end
        end else if (tail_arm && rise) begin
          pend_nx = 1'b1;
        end
      end
      PH_ARM: begin
        if (!en) begin
          ph_nx = PH_PAD;
        end else if (rise) begin
          ph_nx = PH_RUN;
          start = 1'b1;
        end
      end
      default: ph_nx = PH_PAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph          <= PH_PAD;
      pend        <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      ph          <= ph_nx;
      pend        <= pend_nx;
      frame_start <= start;
    end

  assign armed    = (ph == PH_ARM) | tail_arm;
  assign rows_run = (ph != PH_ARM);

  // R13: a start pulse never lasts two cycles
  a_r13_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R4: the row pointers are paused only while a trigger would be accepted
  a_r4_pause_means_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !rows_run |-> armed);

  // R6: the first cycle of a frame is always disarmed
  a_r6_start_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !armed);

  // R2 / R9: with triggered mode off for two cycles, nothing is armed
  a_r2_no_arm_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> !armed);

  // R10: the wait meter advances once per paused cycle below saturation
  a_r10_wait_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (!rows_run && $past(!rows_run) && ($past(wait_clks) != '1))
      |-> wait_clks == $past(wait_clks) + 1'b1);

  // R8: a held edge always leads to a start at the frame boundary
  a_r8_pending_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && last && en) |=> frame_start);
endmodule

// File: tb/test_vd_frame_gate.sv
module test_vd_frame_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int T_GPI [NV] = '{0, 1, 0, 0, 1};
  localparam int T_TRG [NV] = '{0, 0, 1, 0, 0};
  localparam int T_LEN [NV] = '{20, 30, 17, 5, 40};
  localparam int T_PAD [NV] = '{3, 0, 5, 2, 10};
  localparam int T_EXP [NV] = '{24, 31, 23, 20, 51};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gpi_en = 1'b0, trig_sel = 1'b0, vd_in = 1'b0;
  logic [15:0] frame_len = 16'd20, pad_clks = 16'd3;
  logic        frame_start, armed, rows_run;
  logic [15:0] wait_clks;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vd_frame_gate i_vd_frame_gate (
    .clk(clk), .rst_n(rst_n), .gpi_en(gpi_en), .trig_sel(trig_sel),
    .vd_in(vd_in), .frame_len(frame_len), .pad_clks(pad_clks),
    .frame_start(frame_start), .armed(armed), .rows_run(rows_run),
    .wait_clks(wait_clks)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges until frame_start is seen (limit guards a hang)
  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!frame_start && n < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n, starts, arm_hits, run_low;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(frame_start == 0 && armed == 0 && rows_run == 1 && wait_clks == 0,
          "R1", {frame_start, armed, rows_run}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_start == 0 && armed == 0 && rows_run == 1,
          "R1", {frame_start, armed, rows_run}, 3'b001);

    // R2 R3 R12: free-running period table
    for (int i = 0; i < NV; i++) begin
      gpi_en = T_GPI[i][0]; trig_sel = T_TRG[i][0];
      frame_len = 16'(T_LEN[i]); pad_clks = 16'(T_PAD[i]);
      vd_in = 1'b0;
      wait_pulse(n);
      wait_pulse(n);
      vd_in = 1'b1;  // R2: trigger input ignored with one enable only
      wait_pulse(n);
      check(n == T_EXP[i], "R3", n, T_EXP[i]);
      @(negedge clk);
      check(frame_start == 0, "R13", frame_start, 0);
      vd_in = 1'b0;
    end

    // R4 R10: arm, pause, trigger
    frame_len = 16'd40; pad_clks = 16'd0;
    gpi_en = 1'b1; trig_sel = 1'b1; vd_in = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (rows_run && n < 200);
    check(armed == 1 && rows_run == 0 && wait_clks == 0, "R4",
          {armed, rows_run, 1'(wait_clks != 0)}, 3'b100);
    repeat (10) @(negedge clk);
    vd_in = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_start && n < 50);
    check(n == 3, "R4", n, 3);
    check(rows_run == 1, "R4", rows_run, 1);
    check(wait_clks == 13, "R10", wait_clks, 13);

    // R6 R5: disarmed window, then held level does not retrigger
    arm_hits = 0;
    for (int c = 1; c <= 23; c++) begin @(negedge clk); arm_hits += armed; end
    check(arm_hits == 0, "R6", arm_hits, 0);
    @(negedge clk);
    check(armed == 1, "R6", armed, 1);
    starts = 0;
    for (int c = 25; c <= 60; c++) begin @(negedge clk); starts += frame_start; end
    check(starts == 0 && rows_run == 0, "R5", starts, 0);
    check(wait_clks == 20, "R10", wait_clks, 20);
    vd_in = 1'b0;
    repeat (3) @(negedge clk);

    // R7: edge in the disarmed window is dropped
    vd_in = 1'b1;
    wait_pulse(n);
    check(n == 3, "R4", n, 3);
    starts = 0;
    for (int c = 1; c <= 50; c++) begin
      @(negedge clk);
      starts += frame_start;
      if (c == 1) vd_in = 1'b0;
      if (c == 5) vd_in = 1'b1;
      if (c == 7) vd_in = 1'b0;
    end
    check(starts == 0 && rows_run == 0, "R7", starts, 0);

    // R8: edge in the armed tail starts the next frame with no pause
    vd_in = 1'b1;
    wait_pulse(n);
    check(n == 3, "R7", n, 3);
    run_low = 0; starts = 0;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      run_low += !rows_run;
      if (c < 40) starts += frame_start;
      if (c == 1) vd_in = 1'b0;
      if (c == 30) vd_in = 1'b1;
      if (c == 34) check(armed == 0, "R8", armed, 0);
      if (c == 40) check(frame_start == 1, "R8", frame_start, 1);
    end
    check(run_low == 0 && starts == 0, "R8", run_low, 0);
    vd_in = 1'b0;

    // R9: clearing the enable mid-frame keeps the frame length
    arm_hits = 0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      arm_hits += armed;
      if (n == 10) trig_sel = 1'b0;
    end while (!frame_start && n < 200);
    check(n == 41 && arm_hits == 0, "R9", n, 41);

    // R11: trigger high across reset release
    trig_sel = 1'b1; vd_in = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    starts = 0;
    for (int c = 1; c <= 20; c++) begin @(negedge clk); starts += frame_start; end
    check(starts == 0 && rows_run == 0 && armed == 1, "R11", starts, 0);
    vd_in = 1'b0;
    repeat (3) @(negedge clk);
    vd_in = 1'b1;
    wait_pulse(n);
    check(n == 3, "R11", n, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule